// File: doc/BRIEF.md
# UART FIFO-mode interrupt identification

This block forms the interrupt request and the interrupt identification code of a UART that runs with its receive and transmit FIFOs enabled. It looks at the receive FIFO fill count against a selectable trigger level. It also takes an error flag for the character at the head of the receive FIFO, a pending flag from an external character-timeout timer, and the transmit FIFO fill count. From these it builds up to four interrupt sources and reports the one with the highest priority as an 8-bit code.

It also keeps the data-ready status bit. This bit sets when a received character is pushed into the receive FIFO and clears once the FIFO is empty. A host write to the transmit holding register acknowledges the transmit request. The request stays quiet until the transmit FIFO again enters the half-empty region. The FIFO storage, the shifters, the baud generator and the timeout timer are outside this block.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset, `irq_o` is 0, `iid_o` is C1h and `data_ready_o` is 0.
- R2: With `fifo_en_i`=1 and `rx_ie_i`=1, receive-data-available is pending while `rx_level_i` is at or above the trigger. The trigger is selected by `trig_sel_i`: 0→1, 1→4, 2→8, 3→14 entries. This pending source reports C4h in the same cycle.
- R3: Receive-data-available stops in the same cycle that `rx_level_i` drops below the trigger.
- R4: Line status is pending when the receive sources are enabled, `rx_head_err_i`=1 and `rx_level_i`≠0. It reports C6h and outranks every other source.
- R5: A pending timeout (`rx_timeout_i`=1, receive sources enabled) reports CCh. It ranks below C4h and above the transmit request.
- R6: `data_ready_o` is 1 from the edge after an `rx_push_i` cycle. It returns to 0 on the edge after a cycle with `rx_level_i`=0 and no push.
- R7: The transmit request becomes pending on the edge after `tx_level_i` moves from above DEPTH/2 (8) to at most 8. It stays pending while the level stays at most 8. It reports C2h, the lowest priority.
- R8: A `thr_wr_i` cycle clears the transmit request on the next edge. The request stays clear until the level next goes from above 8 to at most 8.
- R9: With `fifo_en_i`=0 no source is reported. `rx_ie_i`=0 masks line status, receive data and timeout. `tx_ie_i`=0 masks the transmit request.
- R10: When nothing is pending, `iid_o` is C1h (bit 0 set) and `irq_o` is 0. Otherwise `irq_o` is 1 and bit 0 of `iid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enable |
| rx_ie_i | input | 1 | Receive interrupt enable |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| trig_sel_i | input | 2 | Receive trigger select |
| rx_level_i | input | 5 | Receive FIFO fill count |
| rx_push_i | input | 1 | Character written into receive FIFO |
| rx_head_err_i | input | 1 | Head character has parity, framing or break error |
| rx_timeout_i | input | 1 | Character timeout pending |
| tx_level_i | input | 5 | Transmit FIFO fill count |
| thr_wr_i | input | 1 | Host write to transmit holding register |
| irq_o | output | 1 | Interrupt request |
| iid_o | output | 8 | Interrupt identification code |
| data_ready_o | output | 1 | Receive data ready status |

## Verification
The receive-side sources, the priority code and the request line are combinational. The bench drives inputs on the falling edge and compares one nanosecond later, before the next rising edge, which gives a zero-cycle result. Data-ready and the transmit request are registered once and are due on the first rising edge after the stimulus. For these, the bench waits for that edge and samples one nanosecond after it. The receive sweep covers every trigger, fill count, error, timeout and enable combination. The transmit sweep covers every transmit level after an acknowledge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [7:0] IID_NONE = 8'hC1;
  localparam logic [7:0] IID_LSR  = 8'hC6;
  localparam logic [7:0] IID_RDA  = 8'hC4;
  localparam logic [7:0] IID_TMO  = 8'hCC;
  localparam logic [7:0] IID_TXR  = 8'hC2;

  typedef struct packed {
    logic lsr;
    logic rda;
    logic tmo;
    logic txr;
  } irq_src_t;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_irq_cond.sv
module uart_rx_irq_cond
  import uart_irq_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    trig_sel_i,
  input  logic [CW-1:0] level_i,
  input  logic          push_i,
  input  logic          head_err_i,
  input  logic          timeout_i,
  output logic          lsr_o,
  output logic          rda_o,
  output logic          tmo_o,
  output logic          dr_o
);
  logic [CW-1:0] trig;
  logic          nonempty;
  logic          dr_q;

  assign trig     = CW'(trig_level(trig_sel_i));
  assign nonempty = (level_i != '0);
  assign lsr_o    = en_i & head_err_i & nonempty;
  assign rda_o    = en_i & (level_i >= trig);
  assign tmo_o    = en_i & timeout_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dr_q <= 1'b0;
    else if (push_i)   dr_q <= 1'b1;
    else if (!nonempty) dr_q <= 1'b0;
  end
  assign dr_o = dr_q;

  p_rda_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i < trig) |-> !rda_o);
  p_dr_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> dr_o);
  p_dr_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && level_i == '0) |=> !dr_o);
endmodule

// File: rtl/uart_tx_req.sv
module uart_tx_req #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] level_i,
  input  logic          wr_i,
  output logic          pend_o
);
  localparam int unsigned HALF = DEPTH / 2;

  logic half, half_q, pend_q;

  assign half = (level_i <= CW'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      half_q <= half;
      if (wr_i)                pend_q <= 1'b0;
      else if (half && !half_q) pend_q <= 1'b1;
      else if (!half)          pend_q <= 1'b0;
    end
  end
  assign pend_o = pend_q;

  p_wr_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !pend_o);
  p_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half && !half_q && !wr_i) |=> pend_o);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  irq_src_t   src_i,
  output logic [7:0] iid_o,
  output logic       irq_o
);
  always_comb begin
    if (src_i.lsr)      iid_o = IID_LSR;
    else if (src_i.rda) iid_o = IID_RDA;
    else if (src_i.tmo) iid_o = IID_TMO;
    else if (src_i.txr) iid_o = IID_TXR;
    else                iid_o = IID_NONE;
  end
  assign irq_o = |src_i;

  p_lsr_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i.lsr |-> iid_o == IID_LSR);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (iid_o == IID_NONE && !irq_o));
  p_req_bit0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !iid_o[0]);
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          rx_ie_i,
  input  logic          tx_ie_i,
  input  logic [1:0]    trig_sel_i,
  input  logic [CW-1:0] rx_level_i,
  input  logic          rx_push_i,
  input  logic          rx_head_err_i,
  input  logic          rx_timeout_i,
  input  logic [CW-1:0] tx_level_i,
  input  logic          thr_wr_i,
  output logic          irq_o,
  output logic [7:0]    iid_o,
  output logic          data_ready_o
);
  irq_src_t src;
  logic     tx_pend;

  uart_rx_irq_cond #(.CW(CW)) u_rx (
    .clk_i, .rst_ni,
    .en_i       (fifo_en_i & rx_ie_i),
    .trig_sel_i,
    .level_i    (rx_level_i),
    .push_i     (rx_push_i),
    .head_err_i (rx_head_err_i),
    .timeout_i  (rx_timeout_i),
    .lsr_o      (src.lsr),
    .rda_o      (src.rda),
    .tmo_o      (src.tmo),
    .dr_o       (data_ready_o)
  );

  uart_tx_req #(.DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk_i, .rst_ni,
    .level_i (tx_level_i),
    .wr_i    (thr_wr_i),
    .pend_o  (tx_pend)
  );

  assign src.txr = fifo_en_i & tx_ie_i & tx_pend;

  uart_irq_prio u_prio (
    .clk_i, .rst_ni,
    .src_i (src),
    .iid_o,
    .irq_o
  );

  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> (!irq_o && iid_o == IID_NONE));
  p_rda_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && rx_ie_i && !src.lsr &&
     rx_level_i >= CW'(trig_level(trig_sel_i))) |-> iid_o == IID_RDA);
endmodule

// File: tb/sim_uart_fifo_irq.sv
`timescale 1ns/1ps
module sim_uart_fifo_irq;
  logic       clk = 0, rst_ni = 0;
  logic       fifo_en = 0, rx_ie = 0, tx_ie = 0;
  logic [1:0] trig_sel = 0;
  logic [4:0] rx_level = 0, tx_level = 0;
  logic       rx_push = 0, head_err = 0, tmo = 0, thr_wr = 0;
  logic       irq;
  logic [7:0] iid;
  logic       dr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_fifo_irq u0 (
    .clk_i(clk), .rst_ni, .fifo_en_i(fifo_en), .rx_ie_i(rx_ie), .tx_ie_i(tx_ie),
    .trig_sel_i(trig_sel), .rx_level_i(rx_level), .rx_push_i(rx_push),
    .rx_head_err_i(head_err), .rx_timeout_i(tmo), .tx_level_i(tx_level),
    .thr_wr_i(thr_wr), .irq_o(irq), .iid_o(iid), .data_ready_o(dr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int trig_of(input int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction

  function automatic logic [7:0] exp_iid(input bit fe, input bit rie, input bit tie,
      input int s, input int lvl, input bit e, input bit t, input bit txp);
    bit en = fe & rie;
    if (en && e && lvl != 0) return 8'hC6;
    if (en && lvl >= trig_of(s)) return 8'hC4;
    if (en && t) return 8'hCC;
    if (fe && tie && txp) return 8'hC2;
    return 8'hC1;
  endfunction

  task automatic step_neg; @(negedge clk); endtask
  task automatic after_pos; @(posedge clk); #1; endtask

  initial begin
    #1;
    chk("R1 irq", irq, 0); chk("R1 iid", iid, 8'hC1); chk("R1 dr", dr, 0);
    tx_level = 5'd16;
    repeat (2) step_neg;
    rst_ni = 1;
    #1;
    chk("R1 iid after release", iid, 8'hC1);

    // R2 R3 R4 R5 R9 R10: receive sweep, transmit masked (tx level full)
    for (int fe = 0; fe < 2; fe++)
      for (int rie = 0; rie < 2; rie++)
        for (int s = 0; s < 4; s++)
          for (int lvl = 0; lvl <= 16; lvl++)
            for (int e = 0; e < 2; e++)
              for (int t = 0; t < 2; t++) begin
                step_neg;
                fifo_en = fe[0]; rx_ie = rie[0]; trig_sel = s[1:0];
                rx_level = lvl[4:0]; head_err = e[0]; tmo = t[0];
                #1;
                begin
                  logic [7:0] x;
                  x = exp_iid(fe[0], rie[0], 1'b0, s, lvl, e[0], t[0], 1'b0);
                  chk("R2/R3/R4/R5/R9 iid", iid, x);
                  chk("R10 irq", irq, x != 8'hC1);
                end
              end

    // R6 data ready
    step_neg; rx_level = 0; rx_push = 1;
    after_pos; chk("R6 set", dr, 1);
    step_neg; rx_push = 0; rx_level = 3;
    after_pos; chk("R6 hold", dr, 1);
    step_neg; rx_level = 0;
    after_pos; chk("R6 clear", dr, 0);
    step_neg; rx_push = 1; rx_level = 0;
    after_pos; chk("R6 push over empty", dr, 1);
    step_neg; rx_push = 0;

    // R7 R8 R9: transmit sweep
    fifo_en = 1; rx_ie = 0; head_err = 0; tmo = 0; tx_ie = 1;
    for (int lvl = 0; lvl <= 16; lvl++) begin
      step_neg; tx_level = 16;
      step_neg; thr_wr = 1;
      after_pos; chk("R8 cleared by write", iid, 8'hC1);
      step_neg; thr_wr = 0; tx_level = lvl[4:0];
      after_pos;
      chk("R7 level", iid, (lvl <= 8) ? 8'hC2 : 8'hC1);
      chk("R10 irq tx", irq, lvl <= 8);
      after_pos;
      chk("R7 steady", iid, (lvl <= 8) ? 8'hC2 : 8'hC1);
    end
    // R8: write while staying half-empty keeps it clear
    step_neg; tx_level = 2; thr_wr = 1;
    step_neg; thr_wr = 0; tx_level = 5;
    after_pos; after_pos;
    chk("R8 stays clear", iid, 8'hC1);
    step_neg; tx_ie = 0; tx_level = 12;
    step_neg; tx_level = 4;
    after_pos; chk("R9 tx masked", iid, 8'hC1);
    step_neg; tx_ie = 1; #1;
    chk("R9 tx unmasked", iid, 8'hC2);
    // R5: timeout above transmit, below receive data
    step_neg; rx_ie = 1; tmo = 1; rx_level = 2; trig_sel = 1; #1;
    chk("R5 over tx", iid, 8'hCC);
    step_neg; rx_level = 4; #1;
    chk("R5 under rda", iid, 8'hC4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule